// File: doc/BRIEF.md
# Cascaded Driver Chain Frame Controller

This block is the host-side master for a loop of N cascaded LED driver devices that all use a 194-bit serial frame. It takes one frame per device from a wide parallel bus and loads the frames into a single chain-length shift register. It then clocks them out MSB first on a generated serial clock, farthest device first. When every frame sits in its device, it raises a latch strobe that commits all devices at once.

The loop returns data on a forwarded clock and data pair. In the same clocks that carry the new frames, the block samples the status frames that the devices loaded at the previous latch strobe. When a pass ends it presents those status frames as one 194-bit word per device.

The host chooses one of three operations. It can send a grayscale pass, a dot-correction pass, or a dot-correction pass followed at once by a grayscale pass. The block writes the two control bits of every outgoing frame itself: the frame-type bit and the global LED enable. A start/busy/done handshake frames each operation.

Top module: `chain_frame_ctrl`

## Requirements
- R1: After reset, ser_clk, ser_dat, ser_latch, busy and done are low and every bit of status_frames is zero.
- R2: Each pass produces exactly N_DEV×194 rising edges on ser_clk. ser_dat changes only while ser_clk is low.
- R3: Device k's frame is gs_frames/dc_frames[k×194 +: 194]. The frame of device N_DEV-1 is shifted first and each frame goes MSB first, so after a pass device k (k=0 nearest the controller) holds exactly its own frame.
- R4: In every outgoing frame, bit 193 is replaced by led_en (sampled at start) and bit 192 is replaced by 1 for a dot-correction frame and 0 for a grayscale frame, whatever the input bits are.
- R5: op encoding: 2'b00 sends one grayscale pass from gs_frames; 2'b01 sends one dot-correction pass from dc_frames; 2'b10 sends a dot-correction pass then a grayscale pass, with two latch strobes and one done; 2'b11 behaves as 2'b00.
- R6: ser_clk is high for HALF_DIV system cycles and low for HALF_DIV system cycles while shifting, and it stays low whenever busy is low.
- R7: After the last falling edge of a pass, ser_clk stays low for HALF_DIV cycles. ser_latch is then high for exactly 4×HALF_DIV cycles (two serial periods), and ser_clk stays low throughout.
- R8: ret_dat is sampled at each rising edge of ret_clk, taking the value held just before the edge. The first bit captured in a pass lands in status_frames bit N_DEV×194-1, so device k's returned status appears at status_frames[k×194 +: 194].
- R9: status_frames changes only at the end of a latch strobe and holds its value while a pass is shifting.
- R10: start is accepted only while busy is low. busy is high from the cycle after start until done; done is a single-cycle pulse that coincides with busy falling. A start while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 2 | Operation select, see R5 |
| led_en | input | 1 | Global enable written into every frame |
| gs_frames | input | N_DEV×194 | Grayscale frames, device k at slice k |
| dc_frames | input | N_DEV×194 | Dot-correction frames, device k at slice k |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ser_clk | output | 1 | Generated serial shift clock |
| ser_dat | output | 1 | Serial frame data to the first device |
| ser_latch | output | 1 | Latch strobe to the chain |
| ret_clk | input | 1 | Clock forwarded back from the last device |
| ret_dat | input | 1 | Status data from the last device |
| status_frames | output | N_DEV×194 | Returned status, device k at slice k |

## Verification
The bench drives a three-device loop model that latches frames and returns a different status word at every strobe. Each device gets a different hashed payload, so a swapped device order or reversed bit order gives a mismatch. Grayscale-only, dot-correction-only, combined and reserved operations are each checked against the grayscale and dot-correction registers of every device, which shows whether the frame-type bit steered each frame to the right register. An all-ones payload with the enable low shows whether the control bits are overwritten. Comparing the captured status with the word loaded at the previous strobe shows whether capture takes the right edge and data, and a start issued mid-pass shows that it is ignored.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int FRAME_W = 194;
  localparam int EN_POS  = 193;
  localparam int SEL_POS = 192;

  typedef enum logic [1:0] {
    OP_GS   = 2'b00,
    OP_DC   = 2'b01,
    OP_DCGS = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_LATCH
  } state_e;
endpackage

// File: rtl/half_tick.sv
module half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import ccf_pkg::*;
#(
  parameter int N_DEV = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     shift,
  input  logic                     is_dc,
  input  logic                     led_en,
  input  logic [N_DEV*FRAME_W-1:0] frames_in,
  output logic                     msb
);
  localparam int TOTAL = N_DEV * FRAME_W;

  logic [TOTAL-1:0] composed;
  logic [TOTAL-1:0] sh_q, sh_d;

  always_comb begin
    composed = frames_in;
    for (int k = 0; k < N_DEV; k++) begin
      composed[k*FRAME_W + EN_POS]  = led_en;
      composed[k*FRAME_W + SEL_POS] = is_dc;
    end
  end

  always_comb begin
    if (load)       sh_d = composed;
    else if (shift) sh_d = {sh_q[TOTAL-2:0], 1'b0};
    else            sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[TOTAL-1];
endmodule

// File: rtl/status_rx.sv
module status_rx
  import ccf_pkg::*;
#(
  parameter int N_DEV = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ret_clk,
  input  logic                     ret_dat,
  input  logic                     commit,
  output logic [N_DEV*FRAME_W-1:0] status_out
);
  localparam int TOTAL = N_DEV * FRAME_W;
  localparam int SYNC  = 3;

  logic [SYNC-1:0]  ck_s, dt_s;
  logic             rise;
  logic [TOTAL-1:0] sh_q, sh_d;
  logic [TOTAL-1:0] st_q, st_d;

  // Data tap is one stage older than the clock tap: the bit held before the edge.
  assign rise = ck_s[1] & ~ck_s[2];

  always_comb begin
    sh_d = rise   ? {sh_q[TOTAL-2:0], dt_s[2]} : sh_q;
    st_d = commit ? sh_q : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
      sh_q <= '0;
      st_q <= '0;
    end else begin
      ck_s <= {ck_s[SYNC-2:0], ret_clk};
      dt_s <= {dt_s[SYNC-2:0], ret_dat};
      sh_q <= sh_d;
      st_q <= st_d;
    end
  end

  assign status_out = st_q;
endmodule

// File: rtl/chain_frame_ctrl.sv
module chain_frame_ctrl
  import ccf_pkg::*;
#(
  parameter int N_DEV         = 2,
  parameter int HALF_DIV      = 2,
  parameter int LATCH_PERIODS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               op,
  input  logic                     led_en,
  input  logic [N_DEV*FRAME_W-1:0] gs_frames,
  input  logic [N_DEV*FRAME_W-1:0] dc_frames,
  output logic                     busy,
  output logic                     done,
  output logic                     ser_clk,
  output logic                     ser_dat,
  output logic                     ser_latch,
  input  logic                     ret_clk,
  input  logic                     ret_dat,
  output logic [N_DEV*FRAME_W-1:0] status_frames
);
  localparam int TOTAL       = N_DEV * FRAME_W;
  localparam int BCW         = $clog2(TOTAL);
  localparam int LATCH_TICKS = 2 * LATCH_PERIODS;
  localparam int LCW         = $clog2(LATCH_TICKS + 1);

  logic rst_meta, rst_sys;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sys  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sys  <= rst_meta;
    end
  end

  state_e         state_q, state_d;
  logic           sck_q, sck_d;
  logic           ld_q, ld_d;
  logic           done_q, done_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [LCW-1:0] lt_q, lt_d;
  logic           pend_q, pend_d;
  logic           en_q, en_d;
  logic           dc_q, dc_d;
  logic           tick, load, shift, commit;
  logic           tx_msb;
  logic [TOTAL-1:0] load_src;

  half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_sys),
    .run  (state_q != ST_IDLE),
    .tick (tick)
  );

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    ld_d    = ld_q;
    done_d  = 1'b0;
    bit_d   = bit_q;
    lt_d    = lt_q;
    pend_d  = pend_q;
    en_d    = en_q;
    dc_d    = dc_q;
    load    = 1'b0;
    shift   = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SHIFT;
          en_d    = led_en;
          pend_d  = (op == OP_DCGS);
          dc_d    = (op == OP_DC) || (op == OP_DCGS);
          bit_d   = '0;
          load    = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
          end else begin
            sck_d = 1'b0;
            if (bit_q == BCW'(TOTAL - 1)) begin
              bit_d   = '0;
              state_d = ST_GAP;
            end else begin
              bit_d = bit_q + 1'b1;
              shift = 1'b1;
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          ld_d    = 1'b1;
          lt_d    = '0;
          state_d = ST_LATCH;
        end
      end
      ST_LATCH: begin
        if (tick) begin
          if (lt_q == LCW'(LATCH_TICKS - 1)) begin
            ld_d   = 1'b0;
            commit = 1'b1;
            if (pend_q) begin
              pend_d  = 1'b0;
              dc_d    = 1'b0;
              load    = 1'b1;
              state_d = ST_SHIFT;
            end else begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end
          end else begin
            lt_d = lt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sys) begin
    if (!rst_sys) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      ld_q    <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      lt_q    <= '0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      dc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      ld_q    <= ld_d;
      done_q  <= done_d;
      bit_q   <= bit_d;
      lt_q    <= lt_d;
      pend_q  <= pend_d;
      en_q    <= en_d;
      dc_q    <= dc_d;
    end
  end

  assign load_src = dc_d ? dc_frames : gs_frames;

  frame_tx #(.N_DEV(N_DEV)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sys),
    .load     (load),
    .shift    (shift),
    .is_dc    (dc_d),
    .led_en   (en_d),
    .frames_in(load_src),
    .msb      (tx_msb)
  );

  status_rx #(.N_DEV(N_DEV)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sys),
    .ret_clk   (ret_clk),
    .ret_dat   (ret_dat),
    .commit    (commit),
    .status_out(status_frames)
  );

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign ser_clk   = sck_q;
  assign ser_latch = ld_q;
  assign ser_dat   = (state_q == ST_SHIFT) && tx_msb;
endmodule

// File: rtl/chain_frame_ctrl_chk.sv
module chain_frame_ctrl_chk #(
  parameter int N_DEV         = 2,
  parameter int HALF_DIV      = 2,
  parameter int LATCH_PERIODS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_dat,
  input logic ser_latch
);
  localparam int TOTAL  = N_DEV * 194;
  localparam int LD_LEN = 2 * LATCH_PERIODS * HALF_DIV;
  localparam int RCW    = $clog2(TOTAL + 2);
  localparam int LW     = $clog2(LD_LEN + 2);
  localparam int HW     = $clog2(HALF_DIV + 2);

  logic           prev_clk, prev_dat, prev_ld;
  logic [RCW-1:0] rise_cnt;
  logic [LW-1:0]  ld_cnt;
  logic [HW-1:0]  hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      prev_dat <= 1'b0;
      prev_ld  <= 1'b0;
      rise_cnt <= '0;
      ld_cnt   <= '0;
      hi_cnt   <= '0;
    end else begin
      prev_clk <= ser_clk;
      prev_dat <= ser_dat;
      prev_ld  <= ser_latch;
      if (ser_latch && !prev_ld)      rise_cnt <= '0;
      else if (ser_clk && !prev_clk)  rise_cnt <= rise_cnt + 1'b1;
      ld_cnt <= ser_latch ? ld_cnt + 1'b1 : '0;
      hi_cnt <= ser_clk   ? hi_cnt + 1'b1 : '0;
    end
  end

  // R7
  latch_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_latch |-> !ser_clk);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_latch));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  dat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && prev_clk) |-> (ser_dat == prev_dat));

  // R2
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_latch && !prev_ld) |-> (rise_cnt == RCW'(TOTAL)));

  // R7
  latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_latch && prev_ld) |-> (ld_cnt == LW'(LD_LEN)));

  // R6
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_clk && prev_clk) |-> (hi_cnt == HW'(HALF_DIV)));
endmodule

bind chain_frame_ctrl chain_frame_ctrl_chk #(
  .N_DEV        (N_DEV),
  .HALF_DIV     (HALF_DIV),
  .LATCH_PERIODS(LATCH_PERIODS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_dat  (ser_dat),
  .ser_latch(ser_latch)
);

// File: tb/chain_frame_ctrl_tb.sv
`timescale 1ns/1ps
module chain_frame_ctrl_tb;
  localparam int N    = 3;
  localparam int HALF = 2;
  localparam int LP   = 2;
  localparam int FW   = 194;
  localparam int TOT  = N * FW;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic led_en = 1'b0;
  logic [TOT-1:0] gs_frames = '0;
  logic [TOT-1:0] dc_frames = '0;
  logic busy, done, ser_clk, ser_dat, ser_latch;
  logic ret_clk, ret_dat;
  logic [TOT-1:0] status_frames;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  chain_frame_ctrl #(.N_DEV(N), .HALF_DIV(HALF), .LATCH_PERIODS(LP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .led_en(led_en),
    .gs_frames(gs_frames), .dc_frames(dc_frames),
    .busy(busy), .done(done), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_latch(ser_latch), .ret_clk(ret_clk), .ret_dat(ret_dat),
    .status_frames(status_frames)
  );

  function automatic logic [TOT-1:0] mk_pat(int seed);
    logic [TOT-1:0] v;
    for (int i = 0; i < TOT; i++) begin
      logic [31:0] h;
      h = 32'(seed) * 32'h9E3779B9 + 32'(i) * 32'h85EBCA6B;
      h = h ^ (h >> 13);
      v[i] = h[5] ^ h[19];
    end
    return v;
  endfunction

  function automatic logic [FW-1:0] stat_word(int l, int k);
    logic [TOT-1:0] p;
    p = mk_pat(1000 + l * 16 + k);
    return p[FW-1:0];
  endfunction

  function automatic logic [FW-1:0] comp(logic [TOT-1:0] f, int k, bit dc, bit en);
    logic [FW-1:0] w;
    w = f[k*FW +: FW];
    w[193] = en;
    w[192] = dc;
    return w;
  endfunction

  // Chain model: device 0 nearest the controller, device N-1 returns data.
  logic [FW-1:0] dsr [N];
  logic [FW-1:0] dgs [N];
  logic [FW-1:0] ddc [N];
  int lcnt;

  always @(posedge ser_clk or posedge ser_latch or negedge rst_n) begin
    if (!rst_n) begin
      lcnt = 0;
      for (int k = 0; k < N; k++) begin
        dsr[k] <= stat_word(0, k);
        dgs[k] <= '0;
        ddc[k] <= '0;
      end
    end else if (ser_latch) begin
      lcnt = lcnt + 1;
      for (int k = 0; k < N; k++) begin
        if (dsr[k][192]) ddc[k] <= dsr[k];
        else             dgs[k] <= dsr[k];
        dsr[k] <= stat_word(lcnt, k);
      end
    end else begin
      dsr[0] <= {dsr[0][FW-2:0], ser_dat};
      for (int k = 1; k < N; k++) dsr[k] <= {dsr[k][FW-2:0], dsr[k-1][FW-1]};
    end
  end

  assign ret_clk = ser_clk;
  assign ret_dat = dsr[N-1][FW-1];

  // Output monitor, sampled on the falling system edge.
  int rise_cnt = 0, done_cnt = 0, half_bad = 0, ld_bad = 0, ovl_bad = 0, dat_bad = 0;
  int hi_len = 0, ld_len = 0;
  logic p_sck = 1'b0, p_dat = 1'b0, p_ld = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && !p_sck) rise_cnt++;
      if (done) done_cnt++;
      if (ser_clk) hi_len++;
      else begin
        if (p_sck && hi_len != HALF) half_bad++;
        hi_len = 0;
      end
      if (ser_latch) ld_len++;
      else begin
        if (p_ld && ld_len != 4 * HALF) ld_bad++;
        ld_len = 0;
      end
      if (ser_latch && ser_clk) ovl_bad++;
      if (ser_clk && p_sck && ser_dat != p_dat) dat_bad++;
      p_sck = ser_clk;
      p_dat = ser_dat;
      p_ld  = ser_latch;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [TOT-1:0] act,
                     input logic [TOT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Issue one operation and wait for its done pulse; checks handshake and edge count.
  task automatic run_op(input logic [1:0] o, input bit e, input int passes);
    int r0, d0;
    r0 = rise_cnt;
    d0 = done_cnt;
    @(negedge clk);
    op = o; led_en = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", TOT'(busy), TOT'(1));
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R10 busy low with done", TOT'(busy), TOT'(0));
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", TOT'(done), TOT'(0));
    chk(done_cnt - d0 == 1, "R5 one done per op", TOT'(done_cnt - d0), TOT'(1));
    chk(rise_cnt - r0 == passes * TOT, "R2 shift edges", TOT'(rise_cnt - r0),
        TOT'(passes * TOT));
  endtask

  task automatic chk_regs(input string tag, input logic [TOT-1:0] gsx, input bit gs_dc_en,
                          input bit gs_valid, input logic [TOT-1:0] dcx, input bit dc_en,
                          input bit dc_valid);
    for (int k = 0; k < N; k++) begin
      logic [FW-1:0] eg, ed;
      eg = gs_valid ? comp(gsx, k, 1'b0, gs_dc_en) : '0;
      ed = dc_valid ? comp(dcx, k, 1'b1, dc_en) : '0;
      chk(dgs[k] == eg, $sformatf("%s R3 R4 gs dev%0d", tag, k), TOT'(dgs[k]), TOT'(eg));
      chk(ddc[k] == ed, $sformatf("%s R3 R4 dc dev%0d", tag, k), TOT'(ddc[k]), TOT'(ed));
    end
  endtask

  task automatic chk_status(input string tag);
    for (int k = 0; k < N; k++) begin
      logic [FW-1:0] es;
      es = stat_word(lcnt - 1, k);
      chk(status_frames[k*FW +: FW] == es, $sformatf("%s R8 status dev%0d", tag, k),
          TOT'(status_frames[k*FW +: FW]), TOT'(es));
    end
  endtask

  task automatic t_reset;
    chk(ser_clk == 0 && ser_dat == 0 && ser_latch == 0, "R1 serial lines low",
        TOT'({ser_clk, ser_dat, ser_latch}), TOT'(0));
    chk(busy == 0 && done == 0, "R1 handshake low", TOT'({busy, done}), TOT'(0));
    chk(status_frames == '0, "R1 status zero", status_frames, '0);
  endtask

  logic [TOT-1:0] pa, pb, pc, pd;

  task automatic t_gs_only;
    pa = mk_pat(1);
    gs_frames = pa;
    run_op(2'b00, 1'b1, 1);
    chk(lcnt == 1, "R5 one strobe gs", TOT'(lcnt), TOT'(1));
    chk_regs("gs_only", pa, 1'b1, 1'b1, '0, 1'b0, 1'b0);
    chk_status("gs_only");
  endtask

  task automatic t_dc_only;
    pb = mk_pat(2);
    dc_frames = pb;
    run_op(2'b01, 1'b0, 1);
    chk(lcnt == 2, "R5 one strobe dc", TOT'(lcnt), TOT'(2));
    chk_regs("dc_only", pa, 1'b1, 1'b1, pb, 1'b0, 1'b1);
    chk_status("dc_only");
  endtask

  task automatic t_dual;
    pc = mk_pat(3);
    pd = mk_pat(4);
    dc_frames = pc;
    gs_frames = pd;
    run_op(2'b10, 1'b1, 2);
    chk(lcnt == 4, "R5 two strobes dual", TOT'(lcnt), TOT'(4));
    chk_regs("dual", pd, 1'b1, 1'b1, pc, 1'b1, 1'b1);
    chk_status("dual");
  endtask

  task automatic t_reserved;
    pa = mk_pat(5);
    gs_frames = pa;
    run_op(2'b11, 1'b1, 1);
    chk(lcnt == 5, "R5 reserved op one strobe", TOT'(lcnt), TOT'(5));
    chk_regs("reserved", pa, 1'b1, 1'b1, pc, 1'b1, 1'b1);
    chk_status("reserved");
  endtask

  task automatic t_override;
    gs_frames = '1;
    run_op(2'b00, 1'b0, 1);
    for (int k = 0; k < N; k++) begin
      chk(dgs[k][193] == 1'b0, $sformatf("R4 enable bit dev%0d", k), TOT'(dgs[k][193]), TOT'(0));
      chk(dgs[k][192] == 1'b0, $sformatf("R4 select bit dev%0d", k), TOT'(dgs[k][192]), TOT'(0));
      chk(dgs[k][191:0] == '1, $sformatf("R3 payload ones dev%0d", k), TOT'(dgs[k]), TOT'({192{1'b1}}));
    end
    chk_status("override");
  endtask

  task automatic t_busy_start;
    logic [TOT-1:0] snap;
    int l0, d0;
    snap = status_frames;
    l0 = lcnt;
    d0 = done_cnt;
    pa = mk_pat(6);
    gs_frames = pa;
    dc_frames = mk_pat(7);
    @(negedge clk);
    op = 2'b00; led_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    chk(status_frames == snap, "R9 status held mid pass", status_frames, snap);
    op = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10 start while busy ignored done", TOT'(done_cnt - d0), TOT'(1));
    chk(lcnt - l0 == 1, "R10 start while busy ignored strobe", TOT'(lcnt - l0), TOT'(1));
    chk(busy == 1'b0, "R10 stays idle", TOT'(busy), TOT'(0));
    chk_regs("busy_start", pa, 1'b1, 1'b1, pc, 1'b1, 1'b1);
    chk_status("busy_start");
  endtask

  task automatic t_timing;
    chk(half_bad == 0, "R6 half period", TOT'(half_bad), TOT'(0));
    chk(ld_bad == 0, "R7 latch width", TOT'(ld_bad), TOT'(0));
    chk(ovl_bad == 0, "R7 clock low during latch", TOT'(ovl_bad), TOT'(0));
    chk(dat_bad == 0, "R2 data stable while clock high", TOT'(dat_bad), TOT'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10 act=timeout exp=done");
    summary();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gs_only();
    t_dc_only();
    t_dual();
    t_reserved();
    t_override();
    t_busy_start();
    t_timing();
    summary();
  end
endmodule